// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block produces the address of the next microinstruction for a microcoded control unit. It keeps a current microcode address register, and that register drives the control store directly. On every clock edge the register reloads from one of four sources: its own value plus one, the jump target carried in the current microinstruction, a one-deep return-address register, or a dispatch address that outside logic derives from the machine opcode.

Two fields of the current microinstruction steer the choice. A branch-kind field names the action. A condition-pick field chooses either a constant true or one of the status bits, and the selected value decides whether a jump or a call is taken. A taken call also stores the incremented address in the return register, so a later return resumes at the microinstruction after the call. The control store and the opcode dispatch logic sit outside the block.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0 and the return register is 0. A return issued right after reset therefore leads to address 0.
- R2: A branch that is not taken moves `uaddr` to `uaddr + 1` at the next edge. The sum wraps modulo 2^ADDR_W, so the all-ones address is followed by 0.
- R3: With `br_kind` = 2'b00 (jump) and a true condition, `uaddr` takes `jump_addr` at the next edge.
- R4: `cond_pick` selects the condition as follows: 2'b00 is constant true, 2'b01 is `status_in[0]`, 2'b10 is `status_in[1]`, and 2'b11 is `status_in[2]`.
- R5: With `br_kind` = 2'b01 (call) and a true condition, `uaddr` takes `jump_addr` and the return register takes the old `uaddr + 1` at the same edge.
- R6: The return register changes only on a taken call. A call that is not taken leaves it unchanged, and so do jump, return and map.
- R7: With `br_kind` = 2'b10 (return), `uaddr` takes the return register value whatever the condition is.
- R8: With `br_kind` = 2'b11 (map), `uaddr` takes `map_addr` whatever the condition is.
- R9: The return register holds one entry. A second taken call replaces the saved address, and a return then goes to the address after the second call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_kind | input | 2 | Branch kind of the current microinstruction |
| cond_pick | input | 2 | Condition select of the current microinstruction |
| jump_addr | input | 7 | Jump or call target from the microinstruction |
| status_in | input | 3 | Status bits that conditions can test |
| map_addr | input | 7 | Dispatch address derived from the opcode |
| uaddr | output | 7 | Current microcode address presented to the control store |

## Verification
The assertions assume that the microinstruction fields and status bits are stable and known at each rising edge. They also assume that reset is released away from a clock edge, because the checks compare each new address against the inputs sampled one edge earlier. The bench changes every input on the falling edge only, releases reset on a falling edge, and never drives an unknown value. It reads `uaddr` one time unit after each rising edge.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_e;
endpackage

// File: rtl/ucode_cond_mux.sv
module ucode_cond_mux #(
  parameter int STAT_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [STAT_W-1:0] status,
  output logic              hit
);
  localparam int N_CAND = 1 << SEL_W;

  logic [N_CAND-1:0] cand;

  assign cand[0] = 1'b1;

  genvar k;
  generate
    for (k = 1; k < N_CAND; k++) begin : g_cand
      if (k <= STAT_W) begin : g_stat
        assign cand[k] = status[k-1];
      end else begin : g_pad
        assign cand[k] = 1'b0;
      end
    end
  endgenerate

  assign hit = cand[sel];

  always_comb begin
    if (sel == '0) begin
      assert_const_true_R4: assert (hit == 1'b1);
    end
  end
endmodule

// File: rtl/ucode_ret_reg.sv
module ucode_ret_reg #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save,
  input  logic [ADDR_W-1:0] save_val,
  output logic [ADDR_W-1:0] ret_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_addr <= '0;
    else if (save) ret_addr <= save_val;
  end

  assert_call_saves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> ret_addr == $past(save_val));

  assert_ret_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !save |=> $stable(ret_addr));
endmodule

// File: rtl/ucode_next_sel.sv
module ucode_next_sel
  import ucode_seq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  br_kind_e          kind,
  input  logic              hit,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] jump,
  input  logic [ADDR_W-1:0] ret,
  input  logic [ADDR_W-1:0] map,
  output logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] step,
  output logic              save
);
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  assign step = step_addr(cur);

  always_comb begin
    save = 1'b0;
    nxt  = step;
    unique case (kind)
      BR_JUMP: if (hit) nxt = jump;
      BR_CALL: if (hit) begin
        nxt  = jump;
        save = 1'b1;
      end
      BR_RET:  nxt = ret;
      BR_MAP:  nxt = map;
      default: nxt = step;
    endcase
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int STAT_W = 3,
  localparam int SEL_W = $clog2(STAT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        br_kind,
  input  logic [SEL_W-1:0]  cond_pick,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic [STAT_W-1:0] status_in,
  input  logic [ADDR_W-1:0] map_addr,
  output logic [ADDR_W-1:0] uaddr
);
  typedef logic [ADDR_W-1:0] addr_t;

  br_kind_e kind;
  logic     cond_hit;
  logic     call_save;
  addr_t    ret_q;
  addr_t    nxt_addr;
  addr_t    step_addr;

  assign kind = br_kind_e'(br_kind);

  ucode_cond_mux #(.STAT_W(STAT_W), .SEL_W(SEL_W)) u_cond (
    .sel    (cond_pick),
    .status (status_in),
    .hit    (cond_hit)
  );

  ucode_next_sel #(.ADDR_W(ADDR_W)) u_sel (
    .kind (kind),
    .hit  (cond_hit),
    .cur  (uaddr),
    .jump (jump_addr),
    .ret  (ret_q),
    .map  (map_addr),
    .nxt  (nxt_addr),
    .step (step_addr),
    .save (call_save)
  );

  ucode_ret_reg #(.ADDR_W(ADDR_W)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .save     (call_save),
    .save_val (step_addr),
    .ret_addr (ret_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uaddr <= '0;
    else        uaddr <= nxt_addr;
  end

  assert_not_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == BR_JUMP || kind == BR_CALL) && !cond_hit)
    |=> uaddr == addr_t'($past(uaddr) + 1'b1));

  assert_jump_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_JUMP && cond_hit) |=> uaddr == $past(jump_addr));

  assert_call_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_CALL && cond_hit) |=> uaddr == $past(jump_addr));

  assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_RET) |=> uaddr == $past(ret_q));

  assert_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BR_MAP) |=> uaddr == $past(map_addr));

  assert_save_only_call_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_save |-> (kind == BR_CALL && cond_hit));
endmodule

// File: tb/tb_ucode_seq.sv
`timescale 1ns/100ps
module tb_ucode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] br_kind = 2'b00;
  logic [1:0] cond_pick = 2'b00;
  logic [6:0] jump_addr = '0;
  logic [2:0] status_in = '0;
  logic [6:0] map_addr = '0;
  logic [6:0] uaddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [6:0] pc_m;
  logic [6:0] ret_m;

  always #2.5 clk = ~clk;

  ucode_seq dut (
    .clk(clk), .rst_n(rst_n), .br_kind(br_kind), .cond_pick(cond_pick),
    .jump_addr(jump_addr), .status_in(status_in), .map_addr(map_addr),
    .uaddr(uaddr)
  );

  task automatic check(input logic [6:0] exp, input string req);
    n_chk++;
    if (uaddr !== exp) begin
      n_bad++;
      $display("FAIL %s: uaddr=%0d expected=%0d", req, uaddr, exp);
    end
  endtask

  // Drive one microinstruction, advance one edge, compare with expectation.
  task automatic step(input logic [1:0] k, input logic [1:0] p, input logic [2:0] s,
                      input logic [6:0] j, input logic [6:0] m, input string req);
    logic c;
    @(negedge clk);
    br_kind = k; cond_pick = p; status_in = s; jump_addr = j; map_addr = m;
    c = (p == 2'd0) ? 1'b1 : s[p - 2'd1];
    case (k)
      2'b00: pc_m = c ? j : pc_m + 7'd1;
      2'b01: begin
        if (c) begin ret_m = pc_m + 7'd1; pc_m = j; end
        else pc_m = pc_m + 7'd1;
      end
      2'b10: pc_m = ret_m;
      default: pc_m = m;
    endcase
    @(posedge clk); #1;
    check(pc_m, req);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    br_kind = 2'b00; cond_pick = 2'b01; status_in = 3'b000;
    #1;
    pc_m = 7'd0; ret_m = 7'd0;
    check(7'd0, "R1 reset address");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_sequential;
    step(2'b00, 2'b01, 3'b000, 7'd90, 7'd0, "R2 increment");
    step(2'b00, 2'b01, 3'b000, 7'd90, 7'd0, "R2 increment");
  endtask

  task automatic t_return_after_reset;
    step(2'b10, 2'b00, 3'b000, 7'd9, 7'd9, "R1 return reg cleared");
  endtask

  task automatic t_jump;
    step(2'b00, 2'b00, 3'b000, 7'd40, 7'd0, "R3 unconditional jump");
  endtask

  task automatic t_cond_select;
    step(2'b00, 2'b01, 3'b001, 7'd10, 7'd0, "R4 pick status0 true");
    step(2'b00, 2'b10, 3'b101, 7'd70, 7'd0, "R4 pick status1 false");
    step(2'b00, 2'b10, 3'b010, 7'd20, 7'd0, "R4 pick status1 true");
    step(2'b00, 2'b11, 3'b011, 7'd60, 7'd0, "R4 pick status2 false");
    step(2'b00, 2'b11, 3'b100, 7'd30, 7'd0, "R4 pick status2 true");
  endtask

  task automatic t_call_return;
    step(2'b00, 2'b00, 3'b000, 7'd40, 7'd0, "R3 jump before call");
    step(2'b01, 2'b00, 3'b000, 7'd100, 7'd0, "R5 taken call target");
    step(2'b00, 2'b01, 3'b000, 7'd0, 7'd0, "R2 inside routine");
    step(2'b10, 2'b00, 3'b000, 7'd5, 7'd5, "R5 return lands after call");
  endtask

  task automatic t_call_not_taken;
    step(2'b01, 2'b01, 3'b110, 7'd99, 7'd0, "R6 call not taken");
    step(2'b00, 2'b00, 3'b000, 7'd15, 7'd0, "R3 jump");
    step(2'b11, 2'b00, 3'b000, 7'd0, 7'd3, "R6 map keeps return reg");
    step(2'b10, 2'b01, 3'b000, 7'd77, 7'd77, "R6 R7 return, condition false");
  endtask

  task automatic t_map;
    step(2'b11, 2'b01, 3'b000, 7'd12, 7'h55, "R8 map, condition false");
    step(2'b11, 2'b00, 3'b111, 7'd12, 7'h2a, "R8 map, condition true");
  endtask

  task automatic t_wrap;
    step(2'b00, 2'b00, 3'b000, 7'd127, 7'd0, "R3 jump to top");
    step(2'b01, 2'b10, 3'b000, 7'd1, 7'd0, "R2 wrap to zero");
  endtask

  task automatic t_single_level;
    step(2'b01, 2'b00, 3'b000, 7'd50, 7'd0, "R9 first call");
    step(2'b01, 2'b11, 3'b100, 7'd80, 7'd0, "R9 second call");
    step(2'b10, 2'b00, 3'b000, 7'd0, 7'd0, "R9 return to second caller");
    step(2'b10, 2'b00, 3'b000, 7'd0, 7'd0, "R9 return repeats");
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    pc_m = '0; ret_m = '0;
    repeat (2) @(posedge clk);
    #1;
    check(7'd0, "R1 reset address");
    @(negedge clk);
    rst_n = 1'b1;
    t_sequential();
    do_reset();
    t_return_after_reset();
    t_jump();
    t_cond_select();
    t_call_return();
    t_call_not_taken();
    t_map();
    t_wrap();
    t_single_level();
    do_reset();
    t_return_after_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule